// File: doc/BRIEF.md
# Stack Pointer and Exception Unit

This unit owns the stack pointer and the exception program counter of a processor whose data memory is 16 bits wide, word addressed, with a 20-bit address space. Each request carries a stack-operation code, the address of the instruction that issued it, and, for ordinary loads and stores, the effective data address. For each accepted request the unit returns the stack address the memory stage should use and the stack pointer value after the operation. It also reports whether the request faulted, which of two fault kinds it was, and which handler-vector slot in instruction memory holds the handler address.

Requests arrive on a valid/ready channel and results leave on a second valid/ready channel with a one-entry output register. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer (`rsp_ready` low while `rsp_valid` is high) holds off new requests and leaves every payload field unchanged. Loading the stack pointer, capturing the exception program counter and raising the exception pulse all happen at the accepting clock edge.

Top module: `stk_exc_unit`

## Requirements
- R1: After reset the stack pointer reads 2^20 − 1 (0xFFFFF), the exception program counter reads 0, and `rsp_valid` and `exc_req` are low.
- R2: PUSH (op code 1) returns the current pointer as stack address, then the pointer drops by 1.
- R3: POP (op code 2) on a non-empty stack raises the pointer by 1 and returns the new value as stack address.
- R4: CALL (op 3) and INT (op 5) return the current pointer as stack address, then the pointer drops by 2.
- R5: RET (op 4) and RTI (op 6) with at least two words stacked raise the pointer by 2 and return the new value as stack address. Op 0 leaves the pointer unchanged.
- R6: A POP while the pointer equals 0xFFFFF faults with kind 0 (empty stack) and vector slot 2, and the pointer stays unchanged.
- R7: RET or RTI with fewer than two words stacked (pointer above 0xFFFFD) faults as empty stack (kind 0, slot 2), and the pointer stays unchanged.
- R8: When `req_mem_en` is high and `req_addr` is greater than 0xFF00, the request faults with kind 1 (bad address) and vector slot 4. Address 0xFF00 itself does not fault. A faulting request never moves the pointer.
- R9: When both fault kinds arise on one request, the empty-stack kind (0, slot 2) is reported.
- R10: On every fault the exception program counter captures `req_pc`. A request that does not fault leaves it unchanged.
- R11: `exc_req` is high for exactly the one cycle after a faulting request is accepted, and `rsp_exc` matches it in that cycle.
- R12: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, the payload holds steady, and the pointer does not change even when `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 3 | Stack op: 0 none, 1 push, 2 pop, 3 call, 4 ret, 5 int, 6 rti |
| req_pc | input | 16 | Address of the issuing instruction |
| req_mem_en | input | 1 | Request performs a data load or store at `req_addr` |
| req_addr | input | 20 | Effective data address to range check |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_stack_addr | output | 20 | Stack word address for the memory access |
| rsp_sp | output | 20 | Stack pointer after the operation |
| rsp_exc | output | 1 | Request faulted |
| rsp_exc_kind | output | 1 | 0 empty stack, 1 bad address |
| rsp_vec_slot | output | 3 | Handler vector slot (2 or 4), 0 when no fault |
| exc_req | output | 1 | One-cycle exception request |
| sp_o | output | 20 | Current stack pointer |
| epc_o | output | 16 | Exception program counter |

## Verification
A corrupted stack pointer appears on `sp_o` and `rsp_sp` in the cycle after the faulty update. The next stack request then returns a wrong `rsp_stack_addr`, and near the top of the stack it also mis-reports the empty-stack fault. An error in the fault logic shows as a wrong kind, slot or `exc_req` one cycle after acceptance, and the exception program counter either keeps a stale value or picks up the address of a request that did not fault. Handshake errors are exposed when a stalled result is replaced or the pointer moves while `req_ready` is low.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_INT  = 3'd5,
    OP_RTI  = 3'd6
  } stk_op_e;

  typedef enum logic {
    EXC_EMPTY   = 1'b0,
    EXC_BADADDR = 1'b1
  } exc_kind_e;

  localparam int SLOT_W = 3;
endpackage

// File: rtl/stk_sp_calc.sv
module stk_sp_calc
  import stk_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] sp_q,
  output logic              move,
  output logic [ADDR_W-1:0] sp_next,
  output logic [ADDR_W-1:0] stack_addr,
  output logic              empty_hit
);
  localparam logic [ADDR_W-1:0] SP_TOP = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO    = ADDR_W'(2);

  logic [ADDR_W-1:0] depth;
  stk_op_e           op_e;

  assign depth = SP_TOP - sp_q;
  assign op_e  = stk_op_e'(op);

  always_comb begin
    move       = 1'b0;
    sp_next    = sp_q;
    stack_addr = sp_q;
    empty_hit  = 1'b0;
    unique case (op_e)
      OP_PUSH: begin
        move    = 1'b1;
        sp_next = sp_q - ONE;
      end
      OP_POP: begin
        if (depth == '0) begin
          empty_hit = 1'b1;
        end else begin
          move       = 1'b1;
          sp_next    = sp_q + ONE;
          stack_addr = sp_q + ONE;
        end
      end
      OP_CALL, OP_INT: begin
        move    = 1'b1;
        sp_next = sp_q - TWO;
      end
      OP_RET, OP_RTI: begin
        if (depth < TWO) begin
          empty_hit = 1'b1;
        end else begin
          move       = 1'b1;
          sp_next    = sp_q + TWO;
          stack_addr = sp_q + TWO;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_fault_chk.sv
module stk_fault_chk
  import stk_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int unsigned ADDR_LIMIT = 32'h0000_FF00,
  parameter int unsigned SLOT_EMPTY = 2,
  parameter int unsigned SLOT_BAD   = 4
) (
  input  logic              empty_hit,
  input  logic              mem_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              fault,
  output logic              kind,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(ADDR_LIMIT);

  logic bad_hit;
  assign bad_hit = mem_en && (addr > LIMIT);

  always_comb begin
    fault = 1'b0;
    kind  = EXC_EMPTY;
    slot  = '0;
    if (empty_hit) begin
      fault = 1'b1;
      kind  = EXC_EMPTY;
      slot  = SLOT_W'(SLOT_EMPTY);
    end else if (bad_hit) begin
      fault = 1'b1;
      kind  = EXC_BADADDR;
      slot  = SLOT_W'(SLOT_BAD);
    end
  end
endmodule

// File: rtl/stk_exc_unit.sv
module stk_exc_unit
  import stk_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int          PC_W       = 16,
  parameter int unsigned ADDR_LIMIT = 32'h0000_FF00,
  parameter int unsigned SLOT_EMPTY = 2,
  parameter int unsigned SLOT_BAD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [PC_W-1:0]   req_pc,
  input  logic              req_mem_en,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_stack_addr,
  output logic [ADDR_W-1:0] rsp_sp,
  output logic              rsp_exc,
  output logic              rsp_exc_kind,
  output logic [2:0]        rsp_vec_slot,
  output logic              exc_req,
  output logic [ADDR_W-1:0] sp_o,
  output logic [PC_W-1:0]   epc_o
);
  localparam logic [ADDR_W-1:0] SP_TOP = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] sp_q;
  logic [PC_W-1:0]   epc_q;
  logic              move;
  logic [ADDR_W-1:0] sp_next;
  logic [ADDR_W-1:0] stack_addr;
  logic              empty_hit;
  logic              fault;
  logic              kind;
  logic [SLOT_W-1:0] slot;
  logic              acc;

  stk_sp_calc #(.ADDR_W(ADDR_W)) u_calc (
    .op         (req_op),
    .sp_q       (sp_q),
    .move       (move),
    .sp_next    (sp_next),
    .stack_addr (stack_addr),
    .empty_hit  (empty_hit)
  );

  stk_fault_chk #(
    .ADDR_W     (ADDR_W),
    .ADDR_LIMIT (ADDR_LIMIT),
    .SLOT_EMPTY (SLOT_EMPTY),
    .SLOT_BAD   (SLOT_BAD)
  ) u_chk (
    .empty_hit (empty_hit),
    .mem_en    (req_mem_en),
    .addr      (req_addr),
    .fault     (fault),
    .kind      (kind),
    .slot      (slot)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  // Pointer and exception program counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q    <= SP_TOP;
      epc_q   <= '0;
      exc_req <= 1'b0;
    end else begin
      exc_req <= acc && fault;
      if (acc && fault) begin
        epc_q <= req_pc;
      end else if (acc && move) begin
        sp_q <= sp_next;
      end
    end
  end

  // Output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_stack_addr <= '0;
      rsp_sp         <= SP_TOP;
      rsp_exc        <= 1'b0;
      rsp_exc_kind   <= 1'b0;
      rsp_vec_slot   <= '0;
    end else if (acc) begin
      rsp_valid      <= 1'b1;
      rsp_stack_addr <= stack_addr;
      rsp_sp         <= (fault || !move) ? sp_q : sp_next;
      rsp_exc        <= fault;
      rsp_exc_kind   <= kind;
      rsp_vec_slot   <= slot;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign sp_o  = sp_q;
  assign epc_o = epc_q;

  // R12: no acceptance, no pointer movement
  p_hold_sp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(sp_o));
  // R12: a stalled result stays put
  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_stack_addr) && $stable(rsp_exc));
  // R6: empty pop never moves the pointer
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == 3'd2 && sp_o == SP_TOP |=> sp_o == SP_TOP && exc_req);
  // R2: push lowers pointer by one
  p_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == 3'd1 && !(req_mem_en && req_addr > ADDR_W'(ADDR_LIMIT))
    |=> sp_o == $past(sp_o) - ADDR_W'(1));
  // R10: EPC moves only on a fault
  p_epc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> epc_o == $past(epc_o) || $past(!rst_n));
  // R11: pulse agrees with reported result
  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> rsp_valid && rsp_exc);
  // R9: slot agrees with kind
  p_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_exc |-> rsp_vec_slot == (rsp_exc_kind ? 3'(SLOT_BAD) : 3'(SLOT_EMPTY)));
endmodule

// File: tb/sim_stk_exc_unit.sv
module sim_stk_exc_unit;
  localparam int AW = 20;
  localparam int PW = 16;
  localparam logic [AW-1:0] TOP = 20'hFFFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [PW-1:0] req_pc = '0;
  logic          req_mem_en = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [AW-1:0] rsp_stack_addr;
  logic [AW-1:0] rsp_sp;
  logic          rsp_exc;
  logic          rsp_exc_kind;
  logic [2:0]    rsp_vec_slot;
  logic          exc_req;
  logic [AW-1:0] sp_o;
  logic [PW-1:0] epc_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [AW-1:0] m_sp;
  logic [PW-1:0] m_epc;

  always #10 clk = ~clk;

  stk_exc_unit u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_empty(input logic [2:0] op, input logic [AW-1:0] sp);
    return (op == 3'd2 && sp == TOP) || ((op == 3'd4 || op == 3'd6) && (TOP - sp) < 2);
  endfunction

  function automatic logic [AW-1:0] exp_delta_sp(input logic [2:0] op, input logic [AW-1:0] sp);
    case (op)
      3'd1: return sp - 1;
      3'd2: return sp + 1;
      3'd3, 3'd5: return sp - 2;
      3'd4, 3'd6: return sp + 2;
      default: return sp;
    endcase
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd5: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic do_req(input logic [2:0] op, input logic [PW-1:0] pc,
                        input logic men, input logic [AW-1:0] addr);
    bit e, b, f;
    logic [AW-1:0] nsp, saddr;
    e = exp_empty(op, m_sp);
    b = men && (addr > 20'h0FF00);
    f = e || b;
    nsp = f ? m_sp : exp_delta_sp(op, m_sp);
    saddr = (op == 3'd2 || op == 3'd4 || op == 3'd6) && !e ? nsp : m_sp;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_pc = pc; req_mem_en = men; req_addr = addr;
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (f) m_epc = pc;
    m_sp = nsp;
    if (e) begin
      check("R6/R7 kind", {31'd0, rsp_exc_kind}, 32'd0);
      check("R9 slot", {29'd0, rsp_vec_slot}, 32'd2);
    end else if (b) begin
      check("R8 kind", {31'd0, rsp_exc_kind}, 32'd1);
      check("R8 slot", {29'd0, rsp_vec_slot}, 32'd4);
    end else if (op != 3'd0) begin
      check(op_tag(op), {12'd0, rsp_stack_addr}, {12'd0, saddr});
    end
    check("R11 pulse", {31'd0, exc_req}, {31'd0, f});
    check("R11 rsp_exc", {31'd0, rsp_exc}, {31'd0, f});
    check("R5 sp", {12'd0, sp_o}, {12'd0, m_sp});
    check("R5 rsp_sp", {12'd0, rsp_sp}, {12'd0, m_sp});
    check("R10 epc", {16'd0, epc_o}, {16'd0, m_epc});
    @(negedge clk);
    check("R11 pulse end", {31'd0, exc_req}, 32'd0);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sp", {12'd0, sp_o}, {12'd0, TOP});
    check("R1 epc", {16'd0, epc_o}, 32'd0);
    check("R1 valid", {30'd0, rsp_valid, exc_req}, 32'd0);
    m_sp = TOP; m_epc = '0;

    // R6: pop on empty
    do_req(3'd2, 16'h0101, 1'b0, '0);
    // R2 push, then R7 ret with one word
    do_req(3'd1, 16'h0102, 1'b0, '0);
    do_req(3'd4, 16'h0103, 1'b0, '0);
    do_req(3'd6, 16'h0104, 1'b0, '0);
    // R3 pop back to empty
    do_req(3'd2, 16'h0105, 1'b0, '0);
    // R4 call/int, R5 ret/rti
    do_req(3'd3, 16'h0106, 1'b0, '0);
    do_req(3'd5, 16'h0107, 1'b0, '0);
    do_req(3'd4, 16'h0108, 1'b0, '0);
    do_req(3'd6, 16'h0109, 1'b0, '0);
    // R8 boundary
    do_req(3'd0, 16'h0110, 1'b1, 20'h0FF00);
    do_req(3'd0, 16'h0111, 1'b1, 20'h0FF01);
    do_req(3'd1, 16'h0112, 1'b1, 20'hFFFFF);
    // R9 both faults: pop on empty with bad address
    do_req(3'd2, 16'h0113, 1'b1, 20'h10000);

    // R12 stall
    do_req(3'd1, 16'h0120, 1'b0, '0);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd1; req_mem_en = 1'b0; rsp_ready = 1'b0;
    @(negedge clk);
    m_sp = m_sp - 1;
    req_valid = 1'b1; req_op = 3'd2;
    repeat (2) @(negedge clk);
    check("R12 ready", {31'd0, req_ready}, 32'd0);
    check("R12 sp", {12'd0, sp_o}, {12'd0, m_sp});
    check("R12 payload", {12'd0, rsp_stack_addr}, {12'd0, m_sp + 20'd1});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    m_sp = m_sp + 1;
    check("R12 resume addr", {12'd0, rsp_stack_addr}, {12'd0, m_sp});
    check("R12 resume sp", {12'd0, sp_o}, {12'd0, m_sp});
    @(negedge clk);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      logic [AW-1:0] a;
      op = 3'($urandom_range(0, 6));
      a = ($urandom_range(0, 3) == 0) ? 20'($urandom) : 20'h0FF00 + 20'($urandom_range(0, 2)) - 20'd1;
      do_req(op, 16'($urandom), 1'($urandom_range(0, 3) == 0), a);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule